// File: doc/BRIEF.md
# Expected-Latency Request Dispatcher

This block decides, for every read request leaving the last-level cache, which memory should serve it: the die-stacked DRAM cache or off-chip main memory. It combines three pieces of information. The first is a flag saying whether the request's region may hold modified data. The second is a hit/miss prediction. The third is an estimate of how long each memory would take to serve the request. That estimate is the occupancy of the addressed bank in each memory multiplied by that memory's typical unloaded access time.

Both memory controllers report per-bank occupancy counts as flat input buses. The dispatcher picks one destination and presents the request to that queue with a valid/ready handshake. It holds the requester (ready low) until the chosen queue accepts. A small state machine has two states. In `ST_PASS`, the destination follows the live decision. In `ST_HOLD`, the destination is frozen after a stall.

There are two transitions. The stall transition goes from `ST_PASS` to `ST_HOLD` when a valid request finds its queue not ready. The release transition goes from `ST_HOLD` to `ST_PASS` when the frozen destination queue accepts, or when the request is withdrawn. Any other cycle keeps the current state.

Top module: `xlat_dispatch`

## Requirements
- R1: A valid request with the dirty flag set always goes to the DRAM cache queue, whatever the prediction and the occupancies.
- R2: A valid clean request predicted to miss always goes to the off-chip memory queue.
- R3: The expected latency of each memory is the occupancy of the bank named by that memory's bank field, multiplied by that memory's typical latency. Bank b's count occupies bits [b*CNT_W +: CNT_W] of the occupancy bus, and the other banks have no effect.
- R4: A valid clean request predicted to hit goes off-chip only when the off-chip expected latency is strictly smaller than the cache expected latency.
- R5: A valid clean predicted hit whose two expected latencies are equal, or whose cache latency is smaller, goes to the DRAM cache queue.
- R6: `dest_sel` is one-hot when a request is valid (bit 0 = DRAM cache, bit 1 = off-chip) and zero otherwise. Only the selected queue's valid is high, and both queues receive the request address.
- R7: `req_ready` equals the chosen queue's ready. After a stall, the destination stays frozen until acceptance, even if the occupancies change.
- R8: Products up to the full count and latency range are exact within the 16-bit estimate, so comparisons at the largest counts are correct.
- R9: During and after reset, with no valid request, no queue valid, `req_ready` and `dest_sel` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | ADDR_W | Request address |
| req_cbank | input | BANK_W | Target bank in the DRAM cache |
| req_mbank | input | BANK_W | Target bank in off-chip memory |
| req_phit | input | 1 | Predicted hit in the DRAM cache |
| req_dirty | input | 1 | Region may hold modified data |
| cache_occ | input | BANKS*CNT_W | Per-bank occupancy of the DRAM cache controller |
| mem_occ | input | BANKS*CNT_W | Per-bank occupancy of the off-chip controller |
| cq_valid | output | 1 | Request offered to the DRAM cache queue |
| cq_ready | input | 1 | DRAM cache queue can accept |
| cq_addr | output | ADDR_W | Address toward the DRAM cache queue |
| mq_valid | output | 1 | Request offered to the off-chip queue |
| mq_ready | input | 1 | Off-chip queue can accept |
| mq_addr | output | ADDR_W | Address toward the off-chip queue |
| dest_sel | output | 2 | One-hot destination (bit 0 cache, bit 1 off-chip) |

## Verification
The bench keeps the defaults of 8 banks, 6-bit counts and a 16-bit estimate. It sets the typical latencies to 1000 for the cache and 500 for off-chip memory. With these values, an off-chip count of twice the cache count gives an exact tie, and one count less tips the decision off-chip. This makes the strict-less boundary reachable with small counts. The same values push the cache product to 63000 at a count of 63, close to the top of the 16-bit range.

// File: rtl/xlat_pkg.sv
package xlat_pkg;

    // One-hot destination code: bit 0 DRAM cache, bit 1 off-chip memory
    typedef enum logic [1:0] {
        DST_NONE  = 2'b00,
        DST_CACHE = 2'b01,
        DST_MEM   = 2'b10
    } dest_t;

    typedef enum logic {
        ST_PASS = 1'b0,
        ST_HOLD = 1'b1
    } hold_state_t;

endpackage

// File: rtl/xlat_bank_est.sv
// Expected latency for one memory: addressed bank's occupancy times typical latency (R3, R8)
module xlat_bank_est #(
    parameter int BANKS = 8,
    parameter int CNT_W = 6,
    parameter int LAT_W = 10,
    parameter int EXP_W = 16,
    parameter int unsigned LAT = 40,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
    input  logic [BANKS*CNT_W-1:0] occ_flat,
    input  logic [BANK_W-1:0]      bank,
    output logic [EXP_W-1:0]       est
);
    localparam int PROD_W = CNT_W + LAT_W;
    localparam logic [LAT_W-1:0] LAT_V = LAT_W'(LAT);

    logic [CNT_W-1:0]  cnt;
    logic [PROD_W-1:0] prod;

    always_comb begin
        cnt = '0;
        for (int b = 0; b < BANKS; b++) begin
            if (bank == BANK_W'(b)) cnt = occ_flat[b*CNT_W +: CNT_W];
        end
    end

    assign prod = PROD_W'(cnt) * PROD_W'(LAT_V);

    generate
        if (EXP_W >= PROD_W) begin : g_exact
            assign est = EXP_W'(prod);
        end else begin : g_sat
            assign est = (|prod[PROD_W-1:EXP_W]) ? '1 : prod[EXP_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/xlat_policy.sv
// Steering rule: dirty -> cache (R1), clean miss -> off-chip (R2),
// clean hit -> off-chip only on strictly smaller estimate (R4, R5)
module xlat_policy #(
    parameter int EXP_W = 16
) (
    input  logic              dirty,
    input  logic              phit,
    input  logic [EXP_W-1:0]  est_cache,
    input  logic [EXP_W-1:0]  est_mem,
    output xlat_pkg::dest_t   dest
);
    import xlat_pkg::*;

    always_comb begin
        if (dirty) begin
            dest = DST_CACHE;
        end else if (!phit) begin
            dest = DST_MEM;
        end else if (est_mem < est_cache) begin
            dest = DST_MEM;
        end else begin
            dest = DST_CACHE;
        end
    end

endmodule

// File: rtl/xlat_hold_fsm.sv
// Holds the requester until the chosen queue accepts; freezes the choice after a stall (R7)
module xlat_hold_fsm (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  xlat_pkg::dest_t live_dest,
    input  logic            cq_ready,
    input  logic            mq_ready,
    output xlat_pkg::dest_t dest_sel,
    output logic            req_ready
);
    import xlat_pkg::*;

    hold_state_t state_q, state_d;
    dest_t       held_q;
    logic        tgt_ready;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_PASS;
            held_q  <= DST_NONE;
        end else begin
            state_q <= state_d;
            if (state_q == ST_PASS) held_q <= dest_sel;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            ST_PASS: dest_sel = req_valid ? live_dest : DST_NONE;
            ST_HOLD: dest_sel = req_valid ? held_q : DST_NONE;
            default: dest_sel = DST_NONE;
        endcase
        tgt_ready = ((dest_sel == DST_CACHE) && cq_ready) ||
                    ((dest_sel == DST_MEM)   && mq_ready);
        req_ready = tgt_ready;
    end

    // transitions: stall (PASS->HOLD), release (HOLD->PASS)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_PASS: if (req_valid && !tgt_ready) state_d = ST_HOLD;
            ST_HOLD: if (!req_valid || tgt_ready) state_d = ST_PASS;
            default: state_d = ST_PASS;
        endcase
    end

endmodule

// File: rtl/xlat_dispatch.sv
module xlat_dispatch #(
    parameter int ADDR_W    = 32,
    parameter int BANKS     = 8,
    parameter int CNT_W     = 6,
    parameter int LAT_W     = 10,
    parameter int EXP_W     = 16,
    parameter int unsigned CACHE_LAT = 40,
    parameter int unsigned MEM_LAT   = 60,
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1,
    localparam int OCC_W  = BANKS * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BANK_W-1:0] req_cbank,
    input  logic [BANK_W-1:0] req_mbank,
    input  logic              req_phit,
    input  logic              req_dirty,
    input  logic [OCC_W-1:0]  cache_occ,
    input  logic [OCC_W-1:0]  mem_occ,
    output logic              cq_valid,
    input  logic              cq_ready,
    output logic [ADDR_W-1:0] cq_addr,
    output logic              mq_valid,
    input  logic              mq_ready,
    output logic [ADDR_W-1:0] mq_addr,
    output logic [1:0]        dest_sel
);
    import xlat_pkg::*;

    logic [EXP_W-1:0] est_c, est_m;
    dest_t            live_dest, sel;

    xlat_bank_est #(.BANKS(BANKS), .CNT_W(CNT_W), .LAT_W(LAT_W), .EXP_W(EXP_W), .LAT(CACHE_LAT))
        u_est_cache (.occ_flat(cache_occ), .bank(req_cbank), .est(est_c));

    xlat_bank_est #(.BANKS(BANKS), .CNT_W(CNT_W), .LAT_W(LAT_W), .EXP_W(EXP_W), .LAT(MEM_LAT))
        u_est_mem (.occ_flat(mem_occ), .bank(req_mbank), .est(est_m));

    xlat_policy #(.EXP_W(EXP_W)) u_policy (
        .dirty(req_dirty), .phit(req_phit),
        .est_cache(est_c), .est_mem(est_m), .dest(live_dest)
    );

    xlat_hold_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .live_dest(live_dest),
        .cq_ready(cq_ready), .mq_ready(mq_ready),
        .dest_sel(sel), .req_ready(req_ready)
    );

    // R6: one queue valid at a time, address to both
    assign cq_valid = (sel == DST_CACHE);
    assign mq_valid = (sel == DST_MEM);
    assign cq_addr  = req_addr;
    assign mq_addr  = req_addr;
    assign dest_sel = sel;

endmodule

// File: rtl/xlat_dispatch_chk.sv
module xlat_dispatch_chk #(
    parameter int ADDR_W = 32,
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] req_addr,
    input logic              req_phit,
    input logic              req_dirty,
    input logic              cq_valid,
    input logic              cq_ready,
    input logic [ADDR_W-1:0] cq_addr,
    input logic              mq_valid,
    input logic              mq_ready,
    input logic [1:0]        dest_sel
);
    a_r1_dirty_to_cache: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dirty) |-> (dest_sel == 2'b01));

    a_r2_miss_to_mem: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_dirty && !req_phit) |-> (dest_sel == 2'b10));

    a_r6_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dest_sel) && (req_valid == (dest_sel != 2'b00)));

    a_r6_single_queue: assert property (@(posedge clk) disable iff (!rst_n)
        !(cq_valid && mq_valid));

    a_r6_addr_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        cq_valid |-> (cq_addr == req_addr));

    a_r7_ready_source: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> ((cq_valid && cq_ready) || (mq_valid && mq_ready)));

    a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=> (!req_valid || $stable(dest_sel)));

    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!cq_valid && !mq_valid && !req_ready));

endmodule

bind xlat_dispatch xlat_dispatch_chk #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_phit(req_phit), .req_dirty(req_dirty),
    .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_addr(cq_addr),
    .mq_valid(mq_valid), .mq_ready(mq_ready), .dest_sel(dest_sel)
);

// File: tb/xlat_dispatch_test.sv
`timescale 1ns/1ps
module xlat_dispatch_test;
    localparam int AW = 32;
    localparam int NB = 8;
    localparam int CW = 6;
    localparam int BW = 3;
    localparam int CL = 1000;
    localparam int ML = 500;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic [AW-1:0] req_addr = '0;
    logic [BW-1:0] req_cbank = '0, req_mbank = '0;
    logic          req_phit = 1'b0, req_dirty = 1'b0;
    logic [NB*CW-1:0] cache_occ = '0, mem_occ = '0;
    logic          cq_valid, mq_valid;
    logic          cq_ready = 1'b1, mq_ready = 1'b1;
    logic [AW-1:0] cq_addr, mq_addr;
    logic [1:0]    dest_sel;

    int checks = 0;
    int failures = 0;

    xlat_dispatch #(.ADDR_W(AW), .BANKS(NB), .CNT_W(CW), .LAT_W(10), .EXP_W(16),
                    .CACHE_LAT(CL), .MEM_LAT(ML)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_cbank(req_cbank), .req_mbank(req_mbank),
        .req_phit(req_phit), .req_dirty(req_dirty), .cache_occ(cache_occ),
        .mem_occ(mem_occ), .cq_valid(cq_valid), .cq_ready(cq_ready), .cq_addr(cq_addr),
        .mq_valid(mq_valid), .mq_ready(mq_ready), .mq_addr(mq_addr), .dest_sel(dest_sel)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] expect_dest(input logic d, input logic h, input int cc, input int mc);
        if (d) return 2'b01;
        if (!h) return 2'b10;
        if (mc * ML < cc * CL) return 2'b10;
        return 2'b01;
    endfunction

    // background counts on every bank, then the targets overwrite their own bank
    task automatic load_occ(input int cb, input int mb, input int cc, input int mc);
        for (int b = 0; b < NB; b++) begin
            cache_occ[b*CW +: CW] = CW'((b * 13 + 5) % 64);
            mem_occ[b*CW +: CW]   = CW'((b * 29 + 40) % 64);
        end
        cache_occ[cb*CW +: CW] = CW'(cc);
        mem_occ[mb*CW +: CW]   = CW'(mc);
    endtask

    task automatic one_req(input string req, input logic d, input logic h,
                           input int cb, input int mb, input int cc, input int mc,
                           input logic [AW-1:0] a);
        logic [1:0] e;
        @(negedge clk);
        load_occ(cb, mb, cc, mc);
        req_cbank = BW'(cb); req_mbank = BW'(mb);
        req_dirty = d; req_phit = h; req_addr = a;
        cq_ready = 1'b1; mq_ready = 1'b1;
        req_valid = 1'b1;
        #1;
        e = expect_dest(d, h, cc, mc);
        chk(req, {30'd0, dest_sel}, {30'd0, e});
        chk({req, " ready"}, {31'd0, req_ready}, 32'd1);
        chk({req, " qvalid"}, {30'd0, mq_valid, cq_valid}, {30'd0, e});
        chk({req, " R6 addr"}, (e == 2'b01) ? cq_addr : mq_addr, a);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk({req, " R6 idle"}, {30'd0, dest_sel}, 32'd0);
    endtask

    task automatic t_reset;
        #1;
        chk("R9 reset dest", {30'd0, dest_sel}, 32'd0);
        chk("R9 reset qvalid", {30'd0, cq_valid, mq_valid}, 32'd0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R9 post reset ready", {31'd0, req_ready}, 32'd0);
        chk("R9 post reset dest", {30'd0, dest_sel}, 32'd0);
    endtask

    task automatic t_dirty;
        one_req("R1 dirty hit", 1'b1, 1'b1, 2, 5, 50, 1, 32'h1000_0040);
        one_req("R1 dirty miss", 1'b1, 1'b0, 0, 0, 63, 0, 32'h1000_0080);
    endtask

    task automatic t_miss;
        one_req("R2 clean miss", 1'b0, 1'b0, 1, 1, 0, 63, 32'h2000_0000);
    endtask

    task automatic t_compare;
        one_req("R4 mem less", 1'b0, 1'b1, 4, 4, 5, 9, 32'h3000_0000);
        one_req("R4 empty mem", 1'b0, 1'b1, 4, 4, 1, 0, 32'h3000_0040);
        one_req("R5 tie", 1'b0, 1'b1, 4, 4, 5, 10, 32'h3000_0080);
        one_req("R5 cache less", 1'b0, 1'b1, 4, 4, 5, 11, 32'h3000_00c0);
        one_req("R5 both empty", 1'b0, 1'b1, 4, 4, 0, 0, 32'h3000_0100);
    endtask

    task automatic t_banks;
        one_req("R3 bank3/6", 1'b0, 1'b1, 3, 6, 4, 7, 32'h4000_0000);
        one_req("R3 bank7/2", 1'b0, 1'b1, 7, 2, 4, 20, 32'h4000_0040);
        one_req("R3 bank0/7", 1'b0, 1'b1, 0, 7, 2, 3, 32'h4000_0080);
    endtask

    task automatic t_extreme;
        one_req("R8 full counts", 1'b0, 1'b1, 5, 3, 63, 63, 32'h5000_0000);
        one_req("R8 tie high", 1'b0, 1'b1, 5, 3, 31, 62, 32'h5000_0040);
    endtask

    task automatic t_hold;
        @(negedge clk);
        load_occ(1, 1, 1, 10);
        req_cbank = 3'd1; req_mbank = 3'd1;
        req_dirty = 1'b0; req_phit = 1'b1; req_addr = 32'h6000_0000;
        cq_ready = 1'b0; mq_ready = 1'b1;
        req_valid = 1'b1;
        #1;
        chk("R7 stall dest", {30'd0, dest_sel}, 32'h1);
        chk("R7 stall ready", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        cache_occ[1*CW +: CW] = 6'd63;
        #1;
        chk("R7 frozen dest", {30'd0, dest_sel}, 32'h1);
        chk("R7 frozen mq", {31'd0, mq_valid}, 32'd0);
        chk("R7 frozen ready", {31'd0, req_ready}, 32'd0);
        @(negedge clk);
        cq_ready = 1'b1;
        #1;
        chk("R7 release ready", {31'd0, req_ready}, 32'd1);
        chk("R7 release cq", {31'd0, cq_valid}, 32'd1);
        @(negedge clk);
        #1;
        chk("R7 new decision", {30'd0, dest_sel}, 32'h2);
        req_valid = 1'b0;
        #1;
        chk("R7 idle", {30'd0, dest_sel}, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        t_dirty();
        t_miss();
        t_compare();
        t_banks();
        t_extreme();
        t_hold();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule